// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block gates the power of one switchable logic domain. Software writes a control word on a simple register bus to ask for the domain to be collapsed or restored. A state machine then walks the domain through a fixed order of steps. Going up, it turns on a small group of head switches first, then the rest, then lets go of the isolation clamp and the domain reset, and only then turns the domain clock back on. Going down, it gates the clock, clamps and resets the domain, and then drops every switch at once. Each switch stage and the clock-off stage dwell for 2^n reference-clock cycles, with n taken from its own 4-bit field. A switch stage also waits for the acknowledge of its switch group.

Every new request first passes through a fixed start-up delay. During that delay the status still shows the old state. A hardware-trigger mode lets an external level replace the software bit. When that mode is entered while the domain is on, the block runs a full down-then-up cycle and reports "off" until that cycle has ended. A bypass bit skips the sequencing and jumps straight between the fully-off and fully-on states. A retention bit in the second register drives the flip-flop retention output.

States: OFF, UP_START, UP_FEW, UP_REST, UP_RELEASE, ON, DN_START, DN_CLKOFF and DN_CLAMP.

Transitions:
- OFF→UP_START when power is wanted.
- OFF→ON directly when the bypass bit is set.
- UP_START→UP_FEW when the start delay ends.
- UP_FEW→UP_REST when the wait has ended and the first group acknowledges.
- UP_REST→UP_RELEASE when the wait has ended and the second group acknowledges.
- UP_RELEASE→ON after one cycle.
- ON→DN_START when power is no longer wanted or a forced cycle is pending.
- ON→OFF directly when the bypass bit is set.
- DN_START→DN_CLKOFF when the start delay ends.
- DN_CLKOFF→DN_CLAMP when the clock-off wait ends.
- DN_CLAMP→OFF after one cycle.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset the domain is off. Clock enable and both switch enables are 0, clamp and domain reset are 1, and retention is 0. The control register (address 0x0) reads 0x00000001: the collapse bit is set, all wait fields are 0, and hardware mode and bypass are off. The status register (address 0x4) reads 0x00008000.
- R2: Power-up order is: first switch group, then second group, then clamp and reset released together, then clock enabled. With first-group wait f and second-group wait r, the domain is on (control bit 31 = 1) exactly 10 + 2^f + 2^r cycles after the clock edge that writes collapse bit 0 to 0.
- R3: Power-down order is: clock gated, clock-off wait, clamp and reset asserted for one cycle, then both switch groups dropped in the same cycle. With clock-off wait c, the down-complete flag (status bit 15) is set exactly 10 + 2^c cycles after the edge that writes collapse bit 0 to 1.
- R4: Wait field value n gives a dwell of 2^n reference cycles. The fields are: control bits [15:12] for clock-off, [19:16] for the first switch group, and [23:20] for the second group.
- R5: For 8 cycles after a request is taken, the status keeps the old state. During power-up, bit 31 = 0 and bit 15 = 1, with no switch enabled. During power-down, bit 31 = 1 and the clock stays enabled.
- R6: A switch stage does not advance while the acknowledge of its group is low, however long the wait has run.
- R7: A request that changes during a sequence is held. The running sequence finishes to its stable state, and then the held request is carried out.
- R8: With hardware mode on (control bit 1 = 1), power is wanted exactly when the trigger input is 1, and the collapse bit has no effect.
- R9: Entering hardware mode while the domain is on forces a down-then-up cycle. Control bit 31 reads 0 from the write edge until the domain is back on.
- R10: With bypass set (control bit 2 = 1), one clock edge takes the domain from off to fully on, or from on to fully off.
- R11: Status bit 16 (up-complete) and control bit 31 are 1 only when the domain is on. Status bit 15 (down-complete) is 1 only when it is off. Status bit 11 is read/write and drives the retention output.
- R12: Control bits 0, 1, 2 and [23:12] read back as written. Bit 31 is read-only and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte address: 0x0 control, 0x4 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| hw_trig | input | 1 | Hardware power demand, used in hardware mode |
| few_ack | input | 1 | Acknowledge from the first switch group |
| rest_ack | input | 1 | Acknowledge from the second switch group |
| sw_few_en | output | 1 | Enable for the first switch group |
| sw_rest_en | output | 1 | Enable for the second switch group |
| clk_en | output | 1 | Domain clock enable |
| clamp_en | output | 1 | Output isolation clamp |
| dom_rst | output | 1 | Domain reset |
| ret_en | output | 1 | Flip-flop retention enable |

## Verification
The bench runs a table of wait-field triples through full up-and-down sequences. Because the triples differ, a wrong exponent, a swapped field or a missing stage gives a different latency to on or to off. Traces taken cycle by cycle check the order of the output pins and the 8-cycle window in which the status holds. Separate runs cover these cases:
- acknowledge stalls;
- a request that changes mid-sequence;
- bypass jumps;
- the trigger input, including entering hardware mode while the domain is on, where the status must stay off for the whole forced cycle.

// File: rtl/pds_pkg.sv
package pds_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [3:0] {
        S_OFF,
        S_UP_START,
        S_UP_FEW,
        S_UP_REST,
        S_UP_RELEASE,
        S_ON,
        S_DN_START,
        S_DN_CLKOFF,
        S_DN_CLAMP
    } seq_state_t;

    // register addresses
    localparam logic [3:0] ADDR_CTRL = 4'h0;
    localparam logic [3:0] ADDR_STAT = 4'h4;

    // control register bit positions
    localparam int B_COLLAPSE = 0;
    localparam int B_HWMODE   = 1;
    localparam int B_BYPASS   = 2;
    localparam int L_WCLK     = 12;
    localparam int L_WFEW     = 16;
    localparam int L_WREST    = 20;
    localparam int B_PWRON    = 31;

    // status register bit positions
    localparam int B_UPDONE   = 16;
    localparam int B_DNDONE   = 15;
    localparam int B_RETAIN   = 11;
endpackage

// File: rtl/pds_regs.sv
module pds_regs
    import pds_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              st_on,
    input  logic              dn_done,
    output logic [DATA_W-1:0] rdata,
    output logic              collapse_q,
    output logic              hwmode_q,
    output logic              bypass_q,
    output logic [WAIT_W-1:0] wclk_q,
    output logic [WAIT_W-1:0] wfew_q,
    output logic [WAIT_W-1:0] wrest_q,
    output logic              retain_q,
    output logic              hw_enter
);
    logic sel_ctrl, sel_stat;

    assign sel_ctrl = (addr == ADDR_W'(ADDR_CTRL));
    assign sel_stat = (addr == ADDR_W'(ADDR_STAT));
    assign hw_enter = wr && sel_ctrl && wdata[B_HWMODE] && !hwmode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            collapse_q <= 1'b1;
            hwmode_q   <= 1'b0;
            bypass_q   <= 1'b0;
            wclk_q     <= '0;
            wfew_q     <= '0;
            wrest_q    <= '0;
            retain_q   <= 1'b0;
        end else if (wr) begin
            if (sel_ctrl) begin
                collapse_q <= wdata[B_COLLAPSE];
                hwmode_q   <= wdata[B_HWMODE];
                bypass_q   <= wdata[B_BYPASS];
                wclk_q     <= wdata[L_WCLK  +: WAIT_W];
                wfew_q     <= wdata[L_WFEW  +: WAIT_W];
                wrest_q    <= wdata[L_WREST +: WAIT_W];
            end
            if (sel_stat) begin
                retain_q <= wdata[B_RETAIN];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (sel_ctrl) begin
            rdata[B_COLLAPSE]          = collapse_q;
            rdata[B_HWMODE]            = hwmode_q;
            rdata[B_BYPASS]            = bypass_q;
            rdata[L_WCLK  +: WAIT_W]   = wclk_q;
            rdata[L_WFEW  +: WAIT_W]   = wfew_q;
            rdata[L_WREST +: WAIT_W]   = wrest_q;
            rdata[B_PWRON]             = st_on;
        end else if (sel_stat) begin
            rdata[B_UPDONE] = st_on;
            rdata[B_DNDONE] = dn_done;
            rdata[B_RETAIN] = retain_q;
        end
    end
endmodule

// File: rtl/pds_timer.sv
module pds_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
    import pds_pkg::*;
#(
    parameter int WAIT_W    = 4,
    parameter int CNT_W     = 16,
    parameter int START_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              want_on,
    input  logic              bypass,
    input  logic              hw_enter,
    input  logic              few_ack,
    input  logic              rest_ack,
    input  logic [WAIT_W-1:0] wclk,
    input  logic [WAIT_W-1:0] wfew,
    input  logic [WAIT_W-1:0] wrest,
    input  logic              tmr_done,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              few_en,
    output logic              rest_en,
    output logic              clk_en,
    output logic              clamp,
    output logic              dom_rst,
    output logic              st_on,
    output logic              dn_done
);
    localparam logic [CNT_W-1:0] START_LD = CNT_W'(START_CYC - 1);

    seq_state_t state_q, state_d;
    logic       cyc_pend_q;

    function automatic logic [CNT_W-1:0] dwell(input logic [WAIT_W-1:0] n);
        return (CNT_W'(1) << n) - CNT_W'(1);
    endfunction

    // forced down-then-up cycle on hardware-mode entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               cyc_pend_q <= 1'b0;
        else if (hw_enter && state_q != S_OFF)    cyc_pend_q <= 1'b1;
        else if (state_q == S_OFF)                cyc_pend_q <= 1'b0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF:        if (want_on) state_d = bypass ? S_ON : S_UP_START;
            S_UP_START:   if (tmr_done) state_d = S_UP_FEW;
            S_UP_FEW:     if (tmr_done && few_ack) state_d = S_UP_REST;
            S_UP_REST:    if (tmr_done && rest_ack) state_d = S_UP_RELEASE;
            S_UP_RELEASE: state_d = S_ON;
            S_ON:         if (!want_on || cyc_pend_q) state_d = bypass ? S_OFF : S_DN_START;
            S_DN_START:   if (tmr_done) state_d = S_DN_CLKOFF;
            S_DN_CLKOFF:  if (tmr_done) state_d = S_DN_CLAMP;
            S_DN_CLAMP:   state_d = S_OFF;
            default:      state_d = S_OFF;
        endcase
    end

    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            S_UP_START, S_DN_START: tmr_val = START_LD;
            S_UP_FEW:               tmr_val = dwell(wfew);
            S_UP_REST:              tmr_val = dwell(wrest);
            S_DN_CLKOFF:            tmr_val = dwell(wclk);
            default:                tmr_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        few_en  = 1'b1;
        rest_en = 1'b1;
        clk_en  = 1'b0;
        clamp   = 1'b0;
        dom_rst = 1'b0;
        st_on   = 1'b0;
        dn_done = 1'b0;
        unique case (state_q)
            S_OFF, S_UP_START: begin
                few_en  = 1'b0;
                rest_en = 1'b0;
                clamp   = 1'b1;
                dom_rst = 1'b1;
                dn_done = 1'b1;
            end
            S_UP_FEW: begin
                rest_en = 1'b0;
                clamp   = 1'b1;
                dom_rst = 1'b1;
            end
            S_UP_REST, S_DN_CLAMP: begin
                clamp   = 1'b1;
                dom_rst = 1'b1;
            end
            S_UP_RELEASE, S_DN_CLKOFF: begin
            end
            S_ON, S_DN_START: begin
                clk_en = 1'b1;
                st_on  = !cyc_pend_q;
            end
            default: begin
                few_en  = 1'b0;
                rest_en = 1'b0;
                clamp   = 1'b1;
                dom_rst = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
    import pds_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int WAIT_W    = 4,
    parameter int START_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              hw_trig,
    input  logic              few_ack,
    input  logic              rest_ack,
    output logic              sw_few_en,
    output logic              sw_rest_en,
    output logic              clk_en,
    output logic              clamp_en,
    output logic              dom_rst,
    output logic              ret_en
);
    localparam int CNT_W = 1 << WAIT_W;

    logic              collapse_q, hwmode_q, ovr_q, hw_enter;
    logic [WAIT_W-1:0] wclk_q, wfew_q, wrest_q;
    logic              st_on, dn_done, want_on;
    logic              tmr_load, tmr_done;
    logic [CNT_W-1:0]  tmr_val;

    assign want_on = hwmode_q ? hw_trig : !collapse_q;

    pds_regs #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .st_on      (st_on),
        .dn_done    (dn_done),
        .rdata      (bus_rdata),
        .collapse_q (collapse_q),
        .hwmode_q   (hwmode_q),
        .bypass_q   (ovr_q),
        .wclk_q     (wclk_q),
        .wfew_q     (wfew_q),
        .wrest_q    (wrest_q),
        .retain_q   (ret_en),
        .hw_enter   (hw_enter)
    );

    pds_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    pds_fsm #(.WAIT_W(WAIT_W), .CNT_W(CNT_W), .START_CYC(START_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .want_on  (want_on),
        .bypass   (ovr_q),
        .hw_enter (hw_enter),
        .few_ack  (few_ack),
        .rest_ack (rest_ack),
        .wclk     (wclk_q),
        .wfew     (wfew_q),
        .wrest    (wrest_q),
        .tmr_done (tmr_done),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .few_en   (sw_few_en),
        .rest_en  (sw_rest_en),
        .clk_en   (clk_en),
        .clamp    (clamp_en),
        .dom_rst  (dom_rst),
        .st_on    (st_on),
        .dn_done  (dn_done)
    );
endmodule

// File: rtl/pds_sva.sv
module pds_sva (
    input logic clk,
    input logic rst_n,
    input logic clk_en,
    input logic clamp,
    input logic dom_rst,
    input logic few_en,
    input logic rest_en,
    input logic ovr,
    input logic st_on,
    input logic dn_done
);
    AST_CLK_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> (few_en && rest_en && !clamp && !dom_rst)); // R2

    AST_REST_AFTER_FEW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rest_en) && !ovr) |-> $past(few_en)); // R2

    AST_DROP_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(few_en) && !ovr) |-> ($past(clamp) && $past(dom_rst) && !$past(clk_en))); // R3

    AST_DROP_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(few_en) |-> !rest_en); // R3

    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_on && dn_done)); // R11

    AST_ON_CLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        st_on |-> clk_en); // R11
endmodule

bind pwr_domain_seq pds_sva u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_en  (clk_en),
    .clamp   (clamp_en),
    .dom_rst (dom_rst),
    .few_en  (sw_few_en),
    .rest_en (sw_rest_en),
    .ovr     (ovr_q),
    .st_on   (st_on),
    .dn_done (dn_done)
);

// File: tb/pwr_domain_seq_bench.sv
module pwr_domain_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        hw_trig = 1'b0;
    logic        few_allow = 1'b1, rest_allow = 1'b1;
    logic        few_ack, rest_ack;
    logic        sw_few_en, sw_rest_en, clk_en, clamp_en, dom_rst, ret_en;
    int          checks = 0, errors = 0;

    // {first-group wait, second-group wait, clock-off wait}
    localparam logic [11:0] VEC [0:4] = '{12'h000, 12'h120, 12'h302, 12'h243, 12'h511};

    always #(CLK_PERIOD/2) clk = ~clk;

    assign few_ack  = sw_few_en & few_allow;
    assign rest_ack = sw_rest_en & rest_allow;

    pwr_domain_seq u_pwr_domain_seq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_trig(hw_trig),
        .few_ack(few_ack), .rest_ack(rest_ack), .sw_few_en(sw_few_en),
        .sw_rest_en(sw_rest_en), .clk_en(clk_en), .clamp_en(clamp_en),
        .dom_rst(dom_rst), .ret_en(ret_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_for(input logic [3:0] a, input int b, input logic v,
                            input int limit, output int n);
        logic [31:0] r;
        n = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            rd(a, r);
            if (r[b] == v || n >= limit) break;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int n;
        step(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, r); chk("R1 ctrl reset", r, 32'h0000_0001);
        rd(4'h4, r); chk("R1 stat reset", r, 32'h0000_8000);
        chk("R1 pins", {sw_few_en, sw_rest_en, clk_en, clamp_en, dom_rst, ret_en},
            {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0});

        // R12 readback masking
        wr(4'h0, 32'h7FA5_3FFD);
        rd(4'h0, r); chk("R12 ctrl readback", r, 32'h00A5_3005);
        chk("R12 still off", {24'h0, sw_few_en, clk_en}, 32'h0);
        wr(4'h0, 32'h0000_0001);

        // R11 retention bit
        wr(4'h4, 32'h0000_0800);
        rd(4'h4, r); chk("R11 stat retain", r, 32'h0000_8800);
        chk("R11 ret pin", {31'h0, ret_en}, 32'h1);
        wr(4'h4, 32'h0);
        chk("R11 ret cleared", {31'h0, ret_en}, 32'h0);

        // R4 table of wait triples: up then down latency
        for (int i = 0; i < 5; i++) begin
            logic [3:0] f, rr, c;
            logic [31:0] base;
            {f, rr, c} = VEC[i];
            base = (32'(rr) << 20) | (32'(f) << 16) | (32'(c) << 12);
            wr(4'h0, base);
            wait_for(4'h0, 31, 1'b1, 100000, n);
            chk($sformatf("R4 R2 up latency vec%0d", i), n, 10 + (1 << f) + (1 << rr));
            chk("R2 on pins", {sw_few_en, sw_rest_en, clk_en, clamp_en, dom_rst},
                {1'b1, 1'b1, 1'b1, 1'b0, 1'b0});
            wr(4'h0, base | 32'h1);
            wait_for(4'h4, 15, 1'b1, 100000, n);
            chk($sformatf("R4 R3 down latency vec%0d", i), n, 10 + (1 << c));
            chk("R3 off pins", {sw_few_en, sw_rest_en, clk_en, clamp_en, dom_rst},
                {1'b0, 1'b0, 1'b0, 1'b1, 1'b1});
        end

        // R2 / R5 pin trace, f=1 r=1 c=1
        wr(4'h0, 32'h0011_1000);
        for (int k = 1; k <= 14; k++) begin
            @(posedge clk); @(negedge clk);
            if (k == 8) begin
                rd(4'h4, r);
                chk("R5 up hold", {r[15], 1'b0, sw_few_en}, 3'b100);
                rd(4'h0, r);
                chk("R5 up hold on bit", {31'h0, r[31]}, 32'h0);
            end
            if (k == 9)  chk("R2 few first", {sw_few_en, sw_rest_en, clamp_en}, 3'b101);
            if (k == 11) chk("R2 rest second", {sw_rest_en, clamp_en, clk_en}, 3'b110);
            if (k == 13) chk("R2 release before clock", {clamp_en, dom_rst, clk_en}, 3'b000);
            if (k == 14) chk("R2 clock last", {31'h0, clk_en}, 32'h1);
        end
        wr(4'h0, 32'h0011_1001);
        for (int k = 1; k <= 12; k++) begin
            @(posedge clk); @(negedge clk);
            if (k == 8) begin
                rd(4'h0, r);
                chk("R5 down hold", {r[31], clk_en}, 2'b11);
            end
            if (k == 9)  chk("R3 clock gated", {clk_en, clamp_en, sw_few_en}, 3'b001);
            if (k == 11) chk("R3 clamp before drop", {clamp_en, dom_rst, sw_few_en, sw_rest_en}, 4'b1111);
            if (k == 12) begin
                rd(4'h4, r);
                chk("R3 switches dropped", {sw_few_en, sw_rest_en, r[15]}, 3'b001);
            end
        end

        // R6 acknowledge stall
        few_allow = 1'b0;
        wr(4'h0, 32'h0);
        step(30);
        chk("R6 stalled on ack", {sw_few_en, sw_rest_en}, 2'b10);
        few_allow = 1'b1;
        step(1);
        chk("R6 advance on ack", {31'h0, sw_rest_en}, 32'h1);
        wait_for(4'h0, 31, 1'b1, 100, n);
        chk("R6 on after ack", n, 2);
        wr(4'h0, 32'h1);
        wait_for(4'h4, 15, 1'b1, 100, n);
        chk("R6 back off", n, 11);

        // R7 request held during sequence
        wr(4'h0, 32'h0);
        step(3);
        wr(4'h0, 32'h1);
        wait_for(4'h0, 31, 1'b1, 100, n);
        chk("R7 up completes", n, 8);
        wait_for(4'h4, 15, 1'b1, 100, n);
        chk("R7 held collapse applied", n, 11);

        // R10 bypass
        wr(4'h0, 32'h4);
        step(0);
        @(posedge clk); @(negedge clk);
        rd(4'h0, r);
        chk("R10 bypass on", {r[31], sw_few_en, sw_rest_en, clk_en, clamp_en}, 5'b11110);
        wr(4'h0, 32'h5);
        @(posedge clk); @(negedge clk);
        rd(4'h4, r);
        chk("R10 bypass off", {r[15], sw_few_en, clk_en, clamp_en}, 4'b1001);
        wr(4'h0, 32'h1);

        // R8 hardware trigger, collapse bit kept at 1
        wr(4'h0, 32'h3);
        step(5);
        rd(4'h4, r);
        chk("R8 trigger low stays off", {31'h0, r[15]}, 32'h1);
        hw_trig = 1'b1;
        wait_for(4'h0, 31, 1'b1, 100, n);
        chk("R8 trigger on latency", n, 12);
        hw_trig = 1'b0;
        wait_for(4'h4, 15, 1'b1, 100, n);
        chk("R8 trigger off latency", n, 11);
        wr(4'h0, 32'h1);

        // R9 enter hardware mode while on
        wr(4'h0, 32'h0);
        wait_for(4'h0, 31, 1'b1, 100, n);
        hw_trig = 1'b1;
        wr(4'h0, 32'h2);
        rd(4'h0, r);
        chk("R9 status masked at entry", {31'h0, r[31]}, 32'h0);
        wait_for(4'h4, 15, 1'b1, 100, n);
        chk("R9 forced down", n, 11);
        wait_for(4'h0, 31, 1'b1, 100, n);
        chk("R9 back on after cycle", n, 12);
        hw_trig = 1'b0;
        wait_for(4'h4, 15, 1'b1, 100, n);
        chk("R9 off on trigger low", n, 11);
        wr(4'h0, 32'h1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule